// File: doc/BRIEF.md
# Staged Reset Release Sequencer

This block decides when a chip may leave reset after power is applied. It watches two supply comparator flags: one for the main power level and one for the regulator brown-out level. It then runs a fixed chain of timed stages, each measured in pulses of a free-running reference tick. First comes a short extension after the main supply is good. Next it waits for the regulator level and runs a second extension. Last is a power-up delay picked from eight values.

Only after that chain does the system reset output go low. Its release is what lets the oscillator start. The sequencer then waits for the oscillator's clock-ready flag. When the flag is seen, it emits a one-cycle start-fetch strobe together with the reset vector. If the clock monitor is enabled, a final delay runs before the monitor-arm output is raised.

If either supply flag falls while it is being watched, the whole chain starts again from the first hold stage. The comparators, regulator and oscillator are outside the block and appear only as input flags.

Top module: `rst_release_seq`

## Requirements
- R1: After `rst_n` is released, `seq_stage` is 0, `sys_rst` is 1, and `fetch_go` and `mon_arm` are 0.
- R2: `seq_stage` encodes the stages as 0 wait-power, 1 power-extension, 2 wait-brown-out, 3 brown-out-extension, 4 power-up-delay, 5 wait-clock, 6 monitor-delay and 7 run. Stage 0 is left only when `pwr_ok` is 1. Stage 1 then lasts until `PWR_EXT_TICKS` ticks have been counted in it.
- R3: Stage 2 holds while `brn_ok` is 0. Once `brn_ok` is 1, stage 3 runs for `BRN_EXT_TICKS` ticks and then moves to stage 4.
- R4: Stage 4 lasts `M * TICKS_PER_MS` ticks. M is 0 for `pup_sel` = 0 and 2^k for `pup_sel` = k, with k from 1 to 7, giving 0, 2, 4 … 128. With M = 0, stage 4 lasts exactly one clock cycle.
- R5: `sys_rst` is 1 in stages 0 to 4 and 0 in stages 5 to 7. It falls only on entry to stage 5.
- R6: `clk_ready` has no effect outside stage 5. When it is held high from the start, every earlier stage still runs in order for its full duration.
- R7: In stage 5, a cycle with `clk_ready` = 1 causes `fetch_go` to be 1 for exactly the next cycle. `fetch_addr` always equals `RESET_VEC`, which defaults to 0.
- R8: If `mon_en` is 1 when stage 5 ends, stage 6 runs for `MON_TICKS` ticks, then stage 7 is entered with `mon_arm` = 1. If `mon_en` is 0, stage 7 follows directly and `mon_arm` stays 0. `mon_arm` is never 1 outside stage 7.
- R9: A cycle with `pwr_ok` = 0 in any stage, or with `brn_ok` = 0 in stages 3 to 7, sends the next cycle to stage 0 with `sys_rst` = 1 and `mon_arm` = 0. All stage counting restarts from zero.
- R10: A tick is counted only when `ref_tick` is 1 on a clock edge. A timed stage ends on the edge that counts its last tick. A stage whose duration is 0 ends on the first edge after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| ref_tick | input | 1 | One-cycle pulse of the free-running reference timebase |
| pwr_ok | input | 1 | Main supply is above the power-on threshold |
| brn_ok | input | 1 | Regulator output is above the brown-out threshold |
| clk_ready | input | 1 | Oscillator reports a usable clock |
| mon_en | input | 1 | Clock-failure monitor is enabled |
| pup_sel | input | 3 | Power-up delay select |
| sys_rst | output | 1 | System reset, 1 = held |
| fetch_go | output | 1 | One-cycle strobe to start instruction fetch |
| fetch_addr | output | VEC_W | Address from which fetch starts |
| mon_arm | output | 1 | Clock-failure monitor is armed |
| seq_stage | output | 3 | Current stage code |

## Verification
A stage register that jumps ahead shows on `seq_stage` within one cycle. If the jump passes stage 4, it also drops `sys_rst` early, which is a visible early release of reset. A counter that is off by one moves the stage change by one tick period, so comparing every cycle against an independent model catches it within about two clocks. A restart path that is missed leaves `sys_rst` low, or keeps `mon_arm` high, on the cycle after a supply flag falls.

// File: rtl/rst_release_pkg.sv
package rst_release_pkg;

    typedef enum logic [2:0] {
        SEQ_WAIT_PWR = 3'd0,
        SEQ_PWR_EXT  = 3'd1,
        SEQ_WAIT_BRN = 3'd2,
        SEQ_BRN_EXT  = 3'd3,
        SEQ_PUP_DLY  = 3'd4,
        SEQ_WAIT_CLK = 3'd5,
        SEQ_MON_DLY  = 3'd6,
        SEQ_RUN      = 3'd7
    } seq_stage_t;

    typedef struct packed {
        seq_stage_t stage;
        logic       sys_rst;
        logic       fetch_go;
        logic       mon_arm;
    } seq_regs_t;

endpackage

// File: rtl/pup_delay_lut.sv
module pup_delay_lut #(
    parameter int TICKS_PER_MS = 2,
    parameter int CNT_W        = 10
) (
    input  logic [2:0]       sel_i,
    output logic [CNT_W-1:0] ticks_o
);
    localparam int NSEL = 8;

    logic [CNT_W-1:0] lut [NSEL];

    // Code 0 means no delay; code k selects 2^k ms of ticks.
    for (genvar k = 0; k < NSEL; k++) begin : g_lut
        localparam int MS = (k == 0) ? 0 : (1 << k);
        assign lut[k] = CNT_W'(MS * TICKS_PER_MS);
    end

    assign ticks_o = lut[sel_i];

endmodule

// File: rtl/stage_tick_timer.sv
module stage_tick_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && tick_i) begin
            cnt_d = cnt_next[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Zero duration ends at once; otherwise the last counted tick ends the stage.
    assign done_o = en_i && ((target_i == '0) ||
                             (tick_i && (cnt_next >= {1'b0, target_i})));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && target_i != '0) |-> (cnt_q < target_i)) // R4
        else $error("timer count passed its target");

endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
    import rst_release_pkg::*;
#(
    parameter int          PWR_EXT_TICKS = 3,
    parameter int          BRN_EXT_TICKS = 4,
    parameter int          TICKS_PER_MS  = 2,
    parameter int          MON_TICKS     = 5,
    parameter int          VEC_W         = 24,
    parameter logic [23:0] RESET_VEC     = 24'h000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             pwr_ok,
    input  logic             brn_ok,
    input  logic             clk_ready,
    input  logic             mon_en,
    input  logic [2:0]       pup_sel,
    output logic             sys_rst,
    output logic             fetch_go,
    output logic [VEC_W-1:0] fetch_addr,
    output logic             mon_arm,
    output logic [2:0]       seq_stage
);
    localparam int PUP_MAX  = 128 * TICKS_PER_MS;
    localparam int MAX_AB   = (PWR_EXT_TICKS > BRN_EXT_TICKS) ? PWR_EXT_TICKS : BRN_EXT_TICKS;
    localparam int MAX_ABC  = (MAX_AB > MON_TICKS) ? MAX_AB : MON_TICKS;
    localparam int MAX_TICK = (MAX_ABC > PUP_MAX) ? MAX_ABC : PUP_MAX;
    localparam int CNT_W    = $clog2(MAX_TICK + 1) + 1;

    seq_regs_t        r_d, r_q;
    logic [CNT_W-1:0] pup_ticks;
    logic [CNT_W-1:0] tgt;
    logic             timed;
    logic             stage_done;
    logic             drop;

    pup_delay_lut #(
        .TICKS_PER_MS(TICKS_PER_MS),
        .CNT_W       (CNT_W)
    ) u_lut (
        .sel_i  (pup_sel),
        .ticks_o(pup_ticks)
    );

    // Duration of the current stage; non-timed stages disable the counter.
    always_comb begin
        tgt   = '0;
        timed = 1'b0;
        unique case (r_q.stage)
            SEQ_PWR_EXT: begin tgt = CNT_W'(PWR_EXT_TICKS); timed = 1'b1; end
            SEQ_BRN_EXT: begin tgt = CNT_W'(BRN_EXT_TICKS); timed = 1'b1; end
            SEQ_PUP_DLY: begin tgt = pup_ticks;             timed = 1'b1; end
            SEQ_MON_DLY: begin tgt = CNT_W'(MON_TICKS);     timed = 1'b1; end
            default:     begin tgt = '0;                    timed = 1'b0; end
        endcase
    end

    stage_tick_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (r_d.stage != r_q.stage),
        .en_i    (timed),
        .tick_i  (ref_tick),
        .target_i(tgt),
        .done_o  (stage_done)
    );

    always_comb begin
        r_d          = r_q;
        r_d.fetch_go = 1'b0;
        drop = !pwr_ok ||
               (!brn_ok && (r_q.stage inside {SEQ_BRN_EXT, SEQ_PUP_DLY, SEQ_WAIT_CLK,
                                              SEQ_MON_DLY, SEQ_RUN}));
        if (drop) begin
            r_d.stage   = SEQ_WAIT_PWR;
            r_d.mon_arm = 1'b0;
        end else begin
            unique case (r_q.stage)
                SEQ_WAIT_PWR: r_d.stage = SEQ_PWR_EXT;
                SEQ_PWR_EXT:  if (stage_done) r_d.stage = SEQ_WAIT_BRN;
                SEQ_WAIT_BRN: if (brn_ok)     r_d.stage = SEQ_BRN_EXT;
                SEQ_BRN_EXT:  if (stage_done) r_d.stage = SEQ_PUP_DLY;
                SEQ_PUP_DLY:  if (stage_done) r_d.stage = SEQ_WAIT_CLK;
                SEQ_WAIT_CLK: begin
                    if (clk_ready) begin
                        r_d.fetch_go = 1'b1;
                        r_d.stage    = mon_en ? SEQ_MON_DLY : SEQ_RUN;
                    end
                end
                SEQ_MON_DLY: begin
                    if (stage_done) begin
                        r_d.stage   = SEQ_RUN;
                        r_d.mon_arm = 1'b1;
                    end
                end
                SEQ_RUN:  r_d.stage = SEQ_RUN;
                default:  r_d.stage = SEQ_WAIT_PWR;
            endcase
        end
        r_d.sys_rst = !(r_d.stage inside {SEQ_WAIT_CLK, SEQ_MON_DLY, SEQ_RUN});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stage    <= SEQ_WAIT_PWR;
            r_q.sys_rst  <= 1'b1;
            r_q.fetch_go <= 1'b0;
            r_q.mon_arm  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sys_rst    = r_q.sys_rst;
    assign fetch_go   = r_q.fetch_go;
    assign mon_arm    = r_q.mon_arm;
    assign seq_stage  = r_q.stage;
    assign fetch_addr = VEC_W'(RESET_VEC);

    AST_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (seq_stage == 3'd0 && sys_rst && !mon_arm)) // R9
        else $error("supply drop did not restart");

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> !fetch_go) // R7
        else $error("fetch strobe longer than one cycle");

    AST_GO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> $past(seq_stage == 3'd5 && clk_ready)) // R7
        else $error("fetch strobe without clock ready in wait stage");

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_stage != $past(seq_stage)) |->
            (seq_stage == 3'd0 || seq_stage == $past(seq_stage) + 3'd1 ||
             ($past(seq_stage) == 3'd5 && seq_stage == 3'd7))) // R6
        else $error("stage skipped");

    AST_RELEASE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (seq_stage == 3'd5)) // R5
        else $error("reset released outside entry to wait-clock");

    AST_ARM_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mon_arm |-> (seq_stage == 3'd7)) // R8
        else $error("monitor armed outside run");

endmodule

// File: tb/rst_release_seq_tb_top.sv
module rst_release_seq_tb_top;

    localparam int PWR_T = 3;
    localparam int BRN_T = 4;
    localparam int TPM   = 2;
    localparam int MON_T = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        pwr_ok = 1'b0;
    logic        brn_ok = 1'b0;
    logic        clk_ready = 1'b0;
    logic        mon_en = 1'b0;
    logic [2:0]  pup_sel = 3'd0;
    logic        sys_rst;
    logic        fetch_go;
    logic [23:0] fetch_addr;
    logic        mon_arm;
    logic [2:0]  seq_stage;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int go_seen = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rst_release_seq #(
        .PWR_EXT_TICKS(PWR_T),
        .BRN_EXT_TICKS(BRN_T),
        .TICKS_PER_MS (TPM),
        .MON_TICKS    (MON_T)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .pwr_ok    (pwr_ok),
        .brn_ok    (brn_ok),
        .clk_ready (clk_ready),
        .mon_en    (mon_en),
        .pup_sel   (pup_sel),
        .sys_rst   (sys_rst),
        .fetch_go  (fetch_go),
        .fetch_addr(fetch_addr),
        .mon_arm   (mon_arm),
        .seq_stage (seq_stage)
    );

    // Reference tick: one pulse every second cycle.
    logic tick_ph = 1'b0;
    always @(negedge clk) begin
        tick_ph  <= ~tick_ph;
        ref_tick <= ~tick_ph;
    end

    function automatic int pup_ms(input logic [2:0] s);
        return (s == 3'd0) ? 0 : (1 << s);
    endfunction

    function automatic int dur_of(input int st, input logic [2:0] s);
        case (st)
            1: return PWR_T;
            3: return BRN_T;
            4: return pup_ms(s) * TPM;
            6: return MON_T;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int st);
        case (st)
            0, 1: return "R2";
            2, 3: return "R3";
            4: return "R4";
            5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent cycle model of the stage chain.
    int m_st = 0;
    int m_cnt = 0;
    bit m_go = 1'b0;
    bit m_arm = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_go <= 1'b0; m_arm <= 1'b0;
        end else if (!pwr_ok || (m_st >= 3 && !brn_ok)) begin
            m_st <= 0; m_cnt <= 0; m_go <= 1'b0; m_arm <= 1'b0;
        end else begin
            m_go <= 1'b0;
            case (m_st)
                0: begin m_st <= 1; m_cnt <= 0; end
                2: if (brn_ok) m_st <= 3;
                5: if (clk_ready) begin
                    m_go <= 1'b1;
                    m_st <= mon_en ? 6 : 7;
                end
                7: m_st <= 7;
                default: begin
                    if (dur_of(m_st, pup_sel) == 0 ||
                        (ref_tick && m_cnt + 1 >= dur_of(m_st, pup_sel))) begin
                        m_cnt <= 0;
                        m_st  <= m_st + 1;
                        if (m_st == 6) m_arm <= 1'b1;
                    end else if (ref_tick) begin
                        m_cnt <= m_cnt + 1;
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (fetch_go) go_seen++;
        if (cmp_en) begin
            chk(int'(seq_stage) == m_st, req_of(m_st), "stage", seq_stage, m_st);
            chk(sys_rst == (m_st < 5), "R5", "sys_rst", sys_rst, m_st < 5);
            chk(fetch_go == m_go, "R7", "fetch_go", fetch_go, m_go);
            chk(fetch_addr == 24'h0, "R7", "fetch_addr", fetch_addr, 0);
            chk(mon_arm == m_arm, "R8", "mon_arm", mon_arm, m_arm);
        end
        if (cyc > 150000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wait_stage(input int s, input int max, input string req);
        int n = 0;
        while (int'(seq_stage) != s && n < max) begin
            @(negedge clk);
            n++;
        end
        chk(int'(seq_stage) == s, req, "reach stage", seq_stage, s);
    endtask

    initial begin
        void'($urandom(32'h1D5E_ED01));
        // Reset with clk_ready already high (R6) and monitor enabled.
        clk_ready = 1'b1; mon_en = 1'b1; pup_sel = 3'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(seq_stage == 3'd0, "R1", "stage", seq_stage, 0);
        chk(sys_rst == 1'b1, "R1", "sys_rst", sys_rst, 1);
        chk(fetch_go == 1'b0 && mon_arm == 1'b0, "R1", "go/arm", {fetch_go, mon_arm}, 0);
        cmp_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(seq_stage == 3'd0, "R2", "hold without pwr_ok", seq_stage, 0);
        chk(sys_rst == 1'b1, "R6", "early clk_ready ignored", sys_rst, 1);
        pwr_ok = 1'b1;
        wait_stage(2, 100, "R2");
        repeat (20) @(negedge clk);
        chk(seq_stage == 3'd2, "R3", "hold without brn_ok", seq_stage, 2);
        go_seen = 0;
        brn_ok = 1'b1;
        wait_stage(7, 2000, "R8");
        @(negedge clk);
        chk(mon_arm == 1'b1, "R8", "armed in run", mon_arm, 1);
        chk(go_seen == 1, "R7", "single fetch strobe", go_seen, 1);
        pwr_ok = 1'b0;
        @(negedge clk);
        chk(seq_stage == 3'd0 && sys_rst && !mon_arm, "R9", "restart on drop",
            {seq_stage, sys_rst, mon_arm}, 8'b0000_0010);

        // Zero power-up delay, monitor off, clock arrives late.
        pup_sel = 3'd0; mon_en = 1'b0; clk_ready = 1'b0;
        pwr_ok = 1'b1;
        wait_stage(4, 200, "R4");
        begin
            int n = 0;
            while (seq_stage == 3'd4) begin
                @(negedge clk);
                n++;
            end
            chk(n == 1, "R4", "zero delay lasts one cycle", n, 1);
        end
        repeat (10) @(negedge clk);
        chk(seq_stage == 3'd5 && sys_rst == 1'b0, "R5", "released while waiting clock",
            {seq_stage, sys_rst}, 4'b1010);
        clk_ready = 1'b1;
        wait_stage(7, 10, "R8");
        chk(mon_arm == 1'b0, "R8", "no arm when disabled", mon_arm, 0);

        // Drop of brn_ok in a late stage (R9).
        brn_ok = 1'b0;
        @(negedge clk);
        chk(seq_stage == 3'd0, "R9", "restart on brown-out", seq_stage, 0);
        brn_ok = 1'b1;

        // Random runs, checked each cycle against the model (R10 timing).
        for (int run = 0; run < 40; run++) begin
            pwr_ok = 1'b0;
            repeat (2) @(negedge clk);
            pup_sel = 3'($urandom % 8);
            mon_en  = 1'($urandom % 2);
            for (int c = 0; c < 700; c++) begin
                pwr_ok    = (($urandom % 500) != 0);
                brn_ok    = (($urandom % 300) != 0);
                clk_ready = (($urandom % 4) == 0);
                @(negedge clk);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule